// File: doc/BRIEF.md
# Instruction Patch and Breakpoint Comparator Unit

This debug unit watches the address of every instruction fetch and every data (literal) load that falls in the low 512 MB code region. It holds a bank of address comparators: by default six that respond only to instruction fetches and two that respond only to data loads. When an enabled comparator sees its address, the unit does one of two things. It either redirects the access to one word of a small remap table, or it tells the fetch path to replace the lower halfword, the upper halfword or both halfwords of the fetched word with a breakpoint opcode.

Software sets the unit up through a word-spaced 32-bit register port. A control register at byte offset 0x00 carries the global enable and reports the comparator counts. It accepts a write only when a key bit is set in the same write. The remap table base sits at 0x04, and comparator n sits at 0x08 + 4n. The match outputs are combinational and answer in the same cycle as the access address.

Top module: `patch_match_unit`

## Requirements
- R1: After a synchronous active-low reset, every stored field is zero. Control reads 0x0000_0260, which is a fetch comparator count of 6 in bits [7:4], a load comparator count of 2 in bits [11:8] and a bank count of 0 in bits [13:12]. The remap base reads zero, every comparator reads zero and no output is asserted.
- R2: A control write (byte offset 0x00) changes the global enable in bit 0 only when bit 1 of the written data is 1. Bit 1 always reads back as 0.
- R3: A comparator can hit only when the global enable and its own enable (bit 0 of its register) are both 1.
- R4: The remap base register (offset 0x04) keeps bits [28:5] and reads zero elsewhere. A comparator register (offset 0x08 + 4n) keeps action bits [31:30], address bits [28:2] and enable bit 0, and reads zero in bits 29 and 1.
- R5: An access hits a comparator only if address bits [31:29] are zero and address bits [28:2] equal the comparator's stored bits [28:2]. Address bits [1:0] are ignored.
- R6: A hit with action 0 asserts remap_valid and drives remap_addr = {3'b000, base[28:5], n[2:0], 2'b00}, where n is the index of the comparator that won.
- R7: On a fetch comparator, action 1 asserts bkpt_lo only, action 2 asserts bkpt_hi only, and action 3 asserts both. None of these actions asserts remap_valid.
- R8: Comparators 0 to 5 respond only when acc_is_load is 0. Comparators 6 and 7 respond only when acc_is_load is 1.
- R9: On a load comparator, a nonzero action makes that comparator produce no hit, no remap and no breakpoint.
- R10: When several comparators hit at once, the lowest-numbered one alone decides the outputs.
- R11: The outputs are combinational and follow acc_addr within the same cycle. They are all low while acc_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| acc_valid | input | 1 | Access address is valid this cycle |
| acc_is_load | input | 1 | 1 for a data (literal) load, 0 for an instruction fetch |
| acc_addr | input | 32 | Access byte address |
| remap_valid | output | 1 | Redirect the access to remap_addr |
| remap_addr | output | 32 | Remap table word address |
| bkpt_lo | output | 1 | Replace the lower halfword with a breakpoint |
| bkpt_hi | output | 1 | Replace the upper halfword with a breakpoint |

## Verification
Every stored field can be read back through reg_rdata, so a corrupted enable, action or compare address shows up on the very next read. The same fault also shows up in the same cycle on the next access that targets that comparator, as a missing hit, a hit that should not happen, or the wrong halfword flag. A wrong winner index under priority, or a base bit that was lost, changes remap_addr combinationally in the cycle of the access. For that reason the directed scenarios check the outputs in every access cycle, and they cover overlapping comparators and a mismatch of access type.

// File: rtl/pmu_pkg.sv
// Shared types and register map for the patch and breakpoint comparator unit.
// Assumes a word-spaced register port with byte offsets; low two bits ignored.
package pmu_pkg;

    // Action selected by a comparator on a hit
    typedef enum logic [1:0] {
        ACT_REMAP   = 2'd0,
        ACT_BK_LO   = 2'd1,
        ACT_BK_HI   = 2'd2,
        ACT_BK_BOTH = 2'd3
    } act_t;

    // Stored state of one comparator
    typedef struct packed {
        act_t        act;
        logic [26:0] cmp_word;   // address bits [28:2]
        logic        en;
    } comp_cfg_t;

    // Word indices of the register map
    localparam int unsigned WORD_CTRL  = 0;
    localparam int unsigned WORD_BASE  = 1;
    localparam int unsigned WORD_COMP0 = 2;

    // Remap table index width: 32-byte table, eight words
    localparam int unsigned SLOT_W = 3;

endpackage

// File: rtl/pmu_regfile.sv
// Register storage for the unit: global enable (key-guarded), remap base and
// one configuration word per comparator. Read data is combinational.
// Assumes NUM_CODE + NUM_LIT <= 8 and fits the word index space of REG_AW.
module pmu_regfile
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_CODE = 6,
    parameter int unsigned NUM_LIT  = 2,
    parameter int unsigned REG_AW   = 6,
    localparam int unsigned NUM_COMP = NUM_CODE + NUM_LIT,
    localparam int unsigned WORD_W   = REG_AW - 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic                      glob_en,
    output logic [23:0]               remap_base,
    output comp_cfg_t [NUM_COMP-1:0]  cfg
);

    logic [WORD_W-1:0] word;
    logic [1:0]        unused_lsb;

    assign word       = reg_addr[REG_AW-1:2];
    assign unused_lsb = reg_addr[1:0];

    // Control register: global enable changes only with the key bit set
    always_ff @(posedge clk) begin
        if (!rst_n)
            glob_en <= 1'b0;
        else if (reg_wr && word == WORD_W'(WORD_CTRL) && reg_wdata[1])
            glob_en <= reg_wdata[0];
    end

    // Remap base register: only bits [28:5] are kept
    always_ff @(posedge clk) begin
        if (!rst_n)
            remap_base <= '0;
        else if (reg_wr && word == WORD_W'(WORD_BASE))
            remap_base <= reg_wdata[28:5];
    end

    // One configuration register per comparator
    for (genvar gi = 0; gi < NUM_COMP; gi++) begin : g_cfg
        // Capture action, compare word and enable on a write to this slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg[gi] <= '0;
            else if (reg_wr && word == WORD_W'(WORD_COMP0 + gi)) begin
                cfg[gi].act      <= act_t'(reg_wdata[31:30]);
                cfg[gi].cmp_word <= reg_wdata[28:2];
                cfg[gi].en       <= reg_wdata[0];
            end
        end
    end

    // Read mux: fixed identification fields plus stored state
    always_comb begin
        reg_rdata = '0;
        if (word == WORD_W'(WORD_CTRL)) begin
            reg_rdata[0]     = glob_en;
            reg_rdata[7:4]   = 4'(NUM_CODE);
            reg_rdata[11:8]  = 4'(NUM_LIT);
            reg_rdata[13:12] = 2'd0;
        end else if (word == WORD_W'(WORD_BASE)) begin
            reg_rdata[28:5]  = remap_base;
        end else begin
            for (int i = 0; i < NUM_COMP; i++) begin
                if (word == WORD_W'(WORD_COMP0 + i)) begin
                    reg_rdata[31:30] = cfg[i].act;
                    reg_rdata[28:2]  = cfg[i].cmp_word;
                    reg_rdata[0]     = cfg[i].en;
                end
            end
        end
    end

    // A keyless control write must leave the global enable unchanged
    assert_key_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && word == WORD_W'(WORD_CTRL) && !reg_wdata[1]) |=> $stable(glob_en));

    // A write to another register must leave the remap base unchanged
    assert_base_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && word != WORD_W'(WORD_BASE)) |=> $stable(remap_base));

endmodule

// File: rtl/pmu_comparator.sv
// One address comparator. Reports a qualified hit when the access type fits
// its kind, the upper address bits are zero and the word address matches.
// A literal comparator qualifies only when its action is remap.
module pmu_comparator
    import pmu_pkg::*;
#(
    parameter bit IS_LITERAL = 1'b0
) (
    input  comp_cfg_t    cfg,
    input  logic         glob_en,
    input  logic         acc_valid,
    input  logic         acc_is_load,
    input  logic [29:0]  acc_word,     // access address bits [31:2]
    output logic         hit
);

    logic type_ok;
    logic act_ok;
    logic addr_ok;

    // Kind and action qualification, fixed per instance
    if (IS_LITERAL) begin : g_lit
        assign type_ok = acc_is_load;
        assign act_ok  = (cfg.act == ACT_REMAP);
    end else begin : g_code
        assign type_ok = !acc_is_load;
        assign act_ok  = 1'b1;
    end

    // Address match in the low code region only
    assign addr_ok = (acc_word[29:27] == 3'b000) && (acc_word[26:0] == cfg.cmp_word);

    // Combine all qualifiers into one hit flag
    always_comb begin
        hit = acc_valid && glob_en && cfg.en && type_ok && act_ok && addr_ok;
    end

endmodule

// File: rtl/pmu_arbiter.sv
// Chooses the lowest-numbered hitting comparator and turns its action into
// the remap or breakpoint outputs. Assumes at most 2**SLOT_W comparators.
module pmu_arbiter
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_COMP = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_COMP-1:0]    hits,
    input  act_t [NUM_COMP-1:0]    acts,
    input  logic [23:0]            remap_base,
    output logic [NUM_COMP-1:0]    grant,
    output logic                   remap_valid,
    output logic [31:0]            remap_addr,
    output logic                   bkpt_lo,
    output logic                   bkpt_hi
);

    logic              any;
    logic [SLOT_W-1:0] sel;
    act_t              sel_act;

    // Fixed priority: first set hit from index 0 upward wins
    always_comb begin
        any     = 1'b0;
        sel     = '0;
        sel_act = ACT_REMAP;
        grant   = '0;
        for (int i = 0; i < NUM_COMP; i++) begin
            if (hits[i] && !any) begin
                any      = 1'b1;
                sel      = SLOT_W'(i);
                sel_act  = acts[i];
                grant[i] = 1'b1;
            end
        end
    end

    // Decode the winning action into the port flags
    always_comb begin
        remap_valid = any && (sel_act == ACT_REMAP);
        bkpt_lo     = any && (sel_act == ACT_BK_LO || sel_act == ACT_BK_BOTH);
        bkpt_hi     = any && (sel_act == ACT_BK_HI || sel_act == ACT_BK_BOTH);
        remap_addr  = remap_valid ? {3'b000, remap_base, sel, 2'b00} : 32'd0;
    end

    // At most one comparator is granted per access
    assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // Remap and breakpoint never occur together
    assert_excl_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
        remap_valid |-> !(bkpt_lo || bkpt_hi));

    // A granted comparator below the winner index cannot also be hitting
    assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((hits & (grant - 1'b1)) == '0));

endmodule

// File: rtl/patch_match_unit.sv
// Top of the instruction patch and breakpoint comparator unit. Fetch
// comparators come first, load comparators follow; one configuration word
// per comparator. Outputs are combinational from the access inputs.
module patch_match_unit
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_CODE = 6,
    parameter int unsigned NUM_LIT  = 2,
    parameter int unsigned REG_AW   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic              acc_is_load,
    input  logic [31:0]       acc_addr,
    output logic              remap_valid,
    output logic [31:0]       remap_addr,
    output logic              bkpt_lo,
    output logic              bkpt_hi
);

    localparam int unsigned NUM_COMP = NUM_CODE + NUM_LIT;

    logic                     glob_en;
    logic [23:0]              remap_base;
    comp_cfg_t [NUM_COMP-1:0] cfg;
    logic [NUM_COMP-1:0]      hits;
    act_t [NUM_COMP-1:0]      acts;
    logic [NUM_COMP-1:0]      grant;
    logic [1:0]               unused_acc_lsb;

    assign unused_acc_lsb = acc_addr[1:0];

    pmu_regfile #(
        .NUM_CODE (NUM_CODE),
        .NUM_LIT  (NUM_LIT),
        .REG_AW   (REG_AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .glob_en    (glob_en),
        .remap_base (remap_base),
        .cfg        (cfg)
    );

    // Comparator bank: fetch kind below NUM_CODE, load kind above
    for (genvar gi = 0; gi < NUM_COMP; gi++) begin : g_cmp
        pmu_comparator #(
            .IS_LITERAL (gi >= NUM_CODE)
        ) u_cmp (
            .cfg         (cfg[gi]),
            .glob_en     (glob_en),
            .acc_valid   (acc_valid),
            .acc_is_load (acc_is_load),
            .acc_word    (acc_addr[31:2]),
            .hit         (hits[gi])
        );
        assign acts[gi] = cfg[gi].act;
    end

    pmu_arbiter #(
        .NUM_COMP (NUM_COMP)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .hits        (hits),
        .acts        (acts),
        .remap_base  (remap_base),
        .grant       (grant),
        .remap_valid (remap_valid),
        .remap_addr  (remap_addr),
        .bkpt_lo     (bkpt_lo),
        .bkpt_hi     (bkpt_hi)
    );

    // No output without a valid access
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(remap_valid || bkpt_lo || bkpt_hi));

    // Global enable gates every comparator
    assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (hits == '0));

    // Remap target lies in the low region and is word aligned
    assert_remap_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        remap_valid |-> (remap_addr[31:29] == 3'b000 && remap_addr[1:0] == 2'b00));

    // Accesses outside the low region never hit
    assert_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[31:29] != 3'b000) |-> (grant == '0));

endmodule

// File: tb/patch_match_unit_test.sv
// Directed bench for patch_match_unit: one task per scenario.
module patch_match_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_is_load = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        remap_valid;
    logic [31:0] remap_addr;
    logic        bkpt_lo;
    logic        bkpt_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    patch_match_unit uut (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .acc_valid, .acc_is_load, .acc_addr,
        .remap_valid, .remap_addr, .bkpt_lo, .bkpt_hi
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // Drive an access and compare {remap_valid, bkpt_hi, bkpt_lo} and address
    task automatic acc_chk(input string req, input logic ld, input logic [31:0] a,
                           input logic rv, input logic [31:0] ra,
                           input logic bh, input logic bl);
        acc_valid = 1'b1; acc_is_load = ld; acc_addr = a;
        #1;
        check(req, {29'd0, remap_valid, bkpt_hi, bkpt_lo}, {29'd0, rv, bh, bl});
        check(req, remap_addr, rv ? ra : 32'd0);
        acc_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 6'h00, 32'h0000_0260);
        rd_chk("R1 base", 6'h04, 32'h0);
        rd_chk("R1 comp0", 6'h08, 32'h0);
        rd_chk("R1 comp7", 6'h24, 32'h0);
        acc_chk("R1 idle", 1'b0, 32'h0, 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_key();
        wr(6'h00, 32'h0000_0001);
        rd_chk("R2 nokey", 6'h00, 32'h0000_0260);
        wr(6'h00, 32'h0000_0003);
        rd_chk("R2 key", 6'h00, 32'h0000_0261);
        wr(6'h00, 32'h0000_0000);
        rd_chk("R2 nokey clear", 6'h00, 32'h0000_0261);
    endtask

    task automatic t_bits();
        wr(6'h04, 32'hFFFF_FFFF);
        rd_chk("R4 base", 6'h04, 32'h1FFF_FFE0);
        wr(6'h0C, 32'hFFFF_FFFF);
        rd_chk("R4 comp1", 6'h0C, 32'hDFFF_FFFD);
        wr(6'h0C, 32'h0);
        wr(6'h04, 32'h0000_1000);
        rd_chk("R4 base2", 6'h04, 32'h0000_1000);
    endtask

    task automatic t_gate();
        wr(6'h08, 32'h0000_0101);               // comp0 @0x100 remap
        wr(6'h00, 32'h0000_0002);               // global off, with key
        acc_chk("R3 glob off", 1'b0, 32'h100, 1'b0, 0, 1'b0, 1'b0);
        wr(6'h00, 32'h0000_0003);
        acc_chk("R3 both on", 1'b0, 32'h100, 1'b1, 32'h1000, 1'b0, 1'b0);
        wr(6'h08, 32'h0000_0100);               // comp0 disabled
        acc_chk("R3 comp off", 1'b0, 32'h100, 1'b0, 0, 1'b0, 1'b0);
        wr(6'h08, 32'h0000_0101);
    endtask

    task automatic t_match();
        acc_chk("R5 low bits", 1'b0, 32'h103, 1'b1, 32'h1000, 1'b0, 1'b0);
        acc_chk("R5 next word", 1'b0, 32'h104, 1'b0, 0, 1'b0, 1'b0);
        acc_chk("R5 high region", 1'b0, 32'h2000_0100, 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_remap();
        wr(6'h14, 32'h0000_0201);               // comp3 @0x200
        acc_chk("R6 slot3", 1'b0, 32'h200, 1'b1, 32'h100C, 1'b0, 1'b0);
    endtask

    task automatic t_bkpt();
        wr(6'h10, 32'h4000_0301);               // comp2 lower
        acc_chk("R7 lo", 1'b0, 32'h300, 1'b0, 0, 1'b0, 1'b1);
        wr(6'h10, 32'h8000_0301);
        acc_chk("R7 hi", 1'b0, 32'h300, 1'b0, 0, 1'b1, 1'b0);
        wr(6'h10, 32'hC000_0301);
        acc_chk("R7 both", 1'b0, 32'h302, 1'b0, 0, 1'b1, 1'b1);
    endtask

    task automatic t_kind();
        acc_chk("R8 code on load", 1'b1, 32'h100, 1'b0, 0, 1'b0, 1'b0);
        wr(6'h20, 32'h0000_0401);               // comp6 @0x400
        acc_chk("R8 lit load", 1'b1, 32'h400, 1'b1, 32'h1018, 1'b0, 1'b0);
        acc_chk("R8 lit on fetch", 1'b0, 32'h400, 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic t_lit_act();
        wr(6'h24, 32'hC000_0501);               // comp7 @0x500 action 3
        acc_chk("R9 lit act3", 1'b1, 32'h500, 1'b0, 0, 1'b0, 1'b0);
        wr(6'h24, 32'h4000_0501);
        acc_chk("R9 lit act1", 1'b1, 32'h500, 1'b0, 0, 1'b0, 1'b0);
        wr(6'h24, 32'h0000_0501);
        acc_chk("R9 lit act0", 1'b1, 32'h500, 1'b1, 32'h101C, 1'b0, 1'b0);
    endtask

    task automatic t_prio();
        wr(6'h0C, 32'h0000_0301);               // comp1 remap @0x300, comp2 bkpt
        acc_chk("R10 c1 over c2", 1'b0, 32'h300, 1'b1, 32'h1004, 1'b0, 1'b0);
        wr(6'h18, 32'hC000_0201);               // comp4 bkpt @0x200, comp3 remap
        acc_chk("R10 c3 over c4", 1'b0, 32'h200, 1'b1, 32'h100C, 1'b0, 1'b0);
        wr(6'h14, 32'h0000_0200);               // comp3 off: comp4 now wins
        acc_chk("R10 c4 alone", 1'b0, 32'h200, 1'b0, 0, 1'b1, 1'b1);
    endtask

    task automatic t_comb();
        acc_valid = 1'b0; acc_is_load = 1'b0; acc_addr = 32'h100;
        #1;
        check("R11 invalid", {31'd0, remap_valid | bkpt_lo | bkpt_hi}, 32'd0);
        @(posedge clk); #1;
        acc_valid = 1'b1;
        #1;
        check("R11 same cycle", {31'd0, remap_valid}, 32'd1);
        acc_addr = 32'h300;
        #1;
        check("R11 follows addr", remap_addr, 32'h1004);
        acc_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_key();
        t_bits();
        t_gate();
        t_match();
        t_remap();
        t_bkpt();
        t_kind();
        t_lit_act();
        t_prio();
        t_comb();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule